// File: doc/BRIEF.md
# Edge-Triggered Management Interrupt Recognizer

This block turns an active-low, asynchronous management interrupt pin into a clean, one-shot request for an instruction-boundary sequencer. The pin passes through a reset-to-inactive synchronizer. It then goes to a falling-edge detector, which arms again only after the synchronized pin has been seen inactive for a programmable number of clocks. The detector feeds a single-entry pending slot. Holding the pin low, or pulsing it briefly, gives exactly one request per qualified edge.

The sequencer supplies an instruction-boundary strobe, a locked-bus-sequence flag, a pending-NMI flag and a resume-complete pulse. The block answers with a take pulse in the boundary cycle where the request is accepted. It also gives a grant for the NMI path, which loses to a management take in the same cycle. After a take, new requests are masked until resume completes. One request that arrives during that time is held and is taken at the first boundary after the resume. No enable flag can mask the request, and no request is ever taken inside a locked bus sequence.

Top module: `mirq_recognizer`

## Requirements
- R1: A single clock of low level on `req_n` is enough to produce a request. With the pin low before rising edge 0, `irq_pending` reads 0 in the cycle after edge 1 and 1 in the cycle after edge 2.
- R2: After a request, the edge detector accepts no new falling edge until `req_n` has been sampled high on at least `REARM_CLKS` (default 4) consecutive rising edges. A pulse high for only 3 clocks between two lows produces no second request.
- R3: Holding `req_n` low for any number of clocks produces exactly one request.
- R4: `take_irq` is 1 only in a cycle where `boundary` is 1. No enable input can suppress the request.
- R5: While `locked` is 1, `take_irq` and `nmi_go` stay 0, and a waiting request stays pending.
- R6: A pending, unmasked management request is taken even when `nmi_pending` is 1, and `nmi_go` is 0 in that cycle. When no management take occurs, `nmi_go` is 1 at an unlocked boundary with `nmi_pending` high.
- R7: After a take, no further take occurs until a cycle with `resume_done` = 1 has passed. A `boundary` in the same cycle as `resume_done` is not used. A request held during the masked time is taken at the first boundary after that cycle.
- R8: Only one request can wait. A further edge while `irq_pending` is 1 is dropped: the flag stays 1, and only one take results.
- R9: A pin asserted before rising edge 0 is taken at a boundary in the cycle after edge 2. That is three clocks of setup before the boundary.
- R10: While `rst` is 1 and in the first cycle after it, `take_irq` and `irq_pending` are 0, the synchronizer holds the inactive level, and the edge detector is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Asynchronous active-low management interrupt pin |
| boundary | input | 1 | Instruction boundary strobe from the sequencer |
| locked | input | 1 | High during a locked bus sequence |
| nmi_pending | input | 1 | An NMI is waiting to be taken |
| resume_done | input | 1 | One-cycle pulse when the management handler has resumed |
| take_irq | output | 1 | Management interrupt accepted at this boundary |
| nmi_go | output | 1 | NMI may be taken at this boundary |
| irq_pending | output | 1 | A recognized management request is waiting |

## Verification
Each result has a fixed place in time. The synchronizer and the pending register delay `irq_pending` by two rising edges after the first edge that samples the pin low. `take_irq` and `nmi_go` are combinational and belong to the same cycle as the `boundary`, `locked` and `nmi_pending` values. Mask and re-arm state takes effect from the edge that ends the stimulus cycle. The bench changes every input at the falling edge and samples 4 ns later, just before the rising edge. Each expected value is therefore tied to a known count of rising edges from the stimulus, which is worked out ahead of time in the vector table and in the directed sequences.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    // Default depth of the input synchronizer
    localparam int unsigned MIRQ_SYNC_DFLT  = 2;
    // Default count of inactive samples before the edge detector re-arms
    localparam int unsigned MIRQ_REARM_DFLT = 4;

    // Boundary-side context from the instruction sequencer
    typedef struct packed {
        logic boundary;
        logic locked;
        logic nmi_pending;
        logic resume;
    } mirq_ctx_t;

    // Decisions presented back to the sequencer
    typedef struct packed {
        logic take;
        logic nmi_go;
        logic pending;
    } mirq_dec_t;

    // Width of a counter that must reach limit-1
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    generate
        if (STAGES < 2) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= async_n;
            end
            assign sync_n = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], async_n};
            end
            assign sync_n = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mirq_edge.sv
module mirq_edge
    import mirq_pkg::*;
#(
    parameter int unsigned REARM = MIRQ_REARM_DFLT
) (
    input  logic clk,
    input  logic rst,
    input  logic level_n,
    output logic fire
);
    localparam int unsigned CW = cnt_width(REARM);
    localparam logic [CW-1:0] LAST = CW'(REARM - 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] quiet;
    } edge_st_t;

    edge_st_t st_q, st_d;

    assign fire = st_q.armed & ~level_n;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            if (!level_n) begin
                st_d.armed = 1'b0;
                st_d.quiet = '0;
            end
        end else if (level_n) begin
            if (st_q.quiet == LAST) begin
                st_d.armed = 1'b1;
                st_d.quiet = '0;
            end else begin
                st_d.quiet = st_q.quiet + 1'b1;
            end
        end else begin
            st_d.quiet = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.armed <= 1'b1;
            st_q.quiet <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    held_low_no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_q.armed && !level_n) |=> !st_q.armed);

    // R3
    single_fire_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R2
    rearm_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.armed) |-> $past(level_n));
endmodule

// File: rtl/mirq_gate.sv
module mirq_gate
    import mirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  mirq_ctx_t ctx,
    output mirq_dec_t dec
);
    logic req_q;
    logic mask_q;
    logic take;

    assign take = req_q & ctx.boundary & ~ctx.locked & ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            req_q <= fire | (req_q & ~take);
            if (take)            mask_q <= 1'b1;
            else if (ctx.resume) mask_q <= 1'b0;
        end
    end

    always_comb begin
        dec.take    = take;
        dec.nmi_go  = ctx.boundary & ~ctx.locked & ctx.nmi_pending & ~take;
        dec.pending = req_q;
    end

    // R7
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q && !ctx.resume) |=> mask_q);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && !take) |=> req_q);

    // R5
    take_needs_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mask_q) |-> $past(!ctx.locked && ctx.boundary));
endmodule

// File: rtl/mirq_recognizer.sv
module mirq_recognizer
    import mirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = MIRQ_SYNC_DFLT,
    parameter int unsigned REARM_CLKS  = MIRQ_REARM_DFLT
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic boundary,
    input  logic locked,
    input  logic nmi_pending,
    input  logic resume_done,
    output logic take_irq,
    output logic nmi_go,
    output logic irq_pending
);
    logic      sync_n;
    logic      fire;
    mirq_ctx_t ctx;
    mirq_dec_t dec;

    assign ctx = '{boundary: boundary, locked: locked,
                   nmi_pending: nmi_pending, resume: resume_done};

    mirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_n(req_n), .sync_n(sync_n)
    );

    mirq_edge #(.REARM(REARM_CLKS)) u_edge (
        .clk(clk), .rst(rst), .level_n(sync_n), .fire(fire)
    );

    mirq_gate u_gate (
        .clk(clk), .rst(rst), .fire(fire), .ctx(ctx), .dec(dec)
    );

    assign take_irq    = dec.take;
    assign nmi_go      = dec.nmi_go;
    assign irq_pending = dec.pending;

    // R4
    take_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> boundary);
endmodule

// File: tb/sim_mirq_recognizer.sv
module sim_mirq_recognizer;
    logic clk = 1'b0;
    logic rst, req_n, boundary, locked, nmi_pending, resume_done;
    logic take_irq, nmi_go, irq_pending;
    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    mirq_recognizer u0 (
        .clk(clk), .rst(rst), .req_n(req_n), .boundary(boundary),
        .locked(locked), .nmi_pending(nmi_pending), .resume_done(resume_done),
        .take_irq(take_irq), .nmi_go(nmi_go), .irq_pending(irq_pending)
    );

    // Row bits: {req_n, boundary, locked, nmi_pending, resume | exp take, exp pending, exp nmi_go}
    localparam int NV = 22;
    localparam logic [7:0] VEC [NV] = '{
        8'b01010_001, // c0  pin low one clock, lone NMI granted (R1 R6)
        8'b10000_000, // c1
        8'b11010_001, // c2  not yet pending (R1 R9)
        8'b11010_110, // c3  taken over NMI (R6 R9)
        8'b11000_000, // c4  masked boundary (R7)
        8'b10000_000, // c5
        8'b10000_000, // c6  detector re-armed after this edge
        8'b00000_000, // c7  second edge while masked
        8'b10000_000, // c8
        8'b10000_000, // c9
        8'b11000_010, // c10 held pending, masked (R7)
        8'b10000_010, // c11
        8'b10000_010, // c12
        8'b10000_010, // c13
        8'b00000_010, // c14 third edge while pending (R8)
        8'b10000_010, // c15
        8'b10000_010, // c16
        8'b11001_010, // c17 resume with boundary: not used (R7)
        8'b11110_010, // c18 locked boundary (R5)
        8'b11010_110, // c19 taken after resume (R7 R6)
        8'b10001_000, // c20 resume
        8'b11000_000  // c21 dropped edge gives no take (R8)
    };

    task automatic step(input logic p, input logic b, input logic l,
                        input logic n, input logic r);
        @(negedge clk);
        req_n = p; boundary = b; locked = l; nmi_pending = n; resume_done = r;
        #4;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_n = 1'b1; boundary = 1'b0; locked = 1'b0;
        nmi_pending = 1'b0; resume_done = 1'b0;
        // R10: reset state
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            chk("R10 take in reset", take_irq, 1'b0);
            chk("R10 pending in reset", irq_pending, 1'b0);
        end
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 pending after reset", irq_pending, 1'b0);
        chk("R10 take after reset", take_irq, 1'b0);

        // Table walk
        do_reset();
        for (int i = 0; i < NV; i++) begin
            logic [7:0] v;
            v = VEC[i];
            step(v[7], v[6], v[5], v[4], v[3]);
            chk($sformatf("R1 R4 R5 R6 R7 R8 R9 row %0d take", i), take_irq, v[2]);
            chk($sformatf("R1 R5 R7 R8 R9 row %0d pending", i), irq_pending, v[1]);
            chk($sformatf("R5 R6 row %0d nmi_go", i), nmi_go, v[0]);
        end

        // R3: pin held low for many clocks gives one request
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 pending while held low", irq_pending, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 first take", take_irq, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 no second take", take_irq, 1'b0);
        chk("R3 no second pending", irq_pending, 1'b0);

        // R2: three inactive clocks do not re-arm
        do_reset();
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 first take", take_irq, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 short quiet gives no pending", irq_pending, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 short quiet gives no take", take_irq, 1'b0);

        // R2: four inactive clocks re-arm
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 take before re-arm test", take_irq, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 four quiet clocks give pending", irq_pending, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 re-armed request taken", take_irq, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule